// File: doc/BRIEF.md
# SPI slave register interface

This block is the serial control port of a motor gate-driver controller. An external host talks to it with 16-bit frames on a four-wire serial bus. Chip select is active low. The block samples input data on falling SCLK edges and drives output data, MSB first, after rising edges. Each frame carries a read/write flag, a 4-bit address and 11 data bits. The block holds two read-only status words, which the protection logic supplies live, and two read/write control words, which drive the gate decoder and the overcurrent controller.

Responses are pipelined. The word shifted out during a frame answers the frame before it:
- After a valid read, the response echoes the address and returns the register contents.
- After a valid write, the response returns the first status word.
- After a malformed frame, the response carries only a fault flag. A malformed write changes nothing.

The serial pins are brought into the system clock domain through synchronizers, and their edges are detected there. The SCLK period must be at least four system clocks. Any pause between bits is allowed while chip select stays low, so one frame may be sent as two bytes.

Top module: `spi_reg_if`

## Requirements
- R1: After reset both control outputs are zero, SDO is disabled, and the first frame's response is {bit15=0, bits14:11=0, bits10:0=status word 1}.
- R2: Input bits are taken MSB first at falling SCLK edges, as bit15=1 for read and 0 for write, bits14:11 address, bits10:0 data. The response word is presented MSB first, one bit after each rising SCLK edge.
- R3: A valid read of address a in frame N makes the response in frame N+1 equal {0, a, contents of a}: address 0 gives status word 1, address 1 gives status word 2, address 2 gives control word 1 and address 3 gives control word 2.
- R4: A valid write to address 2 or 3 loads that control word and shows it on the matching output once the frame ends. The response in the next frame is {0, 4'b0000, status word 1}. The control outputs change only on such a write.
- R5: A frame is invalid unless SCLK is low when chip select falls, exactly 16 falling SCLK edges occur, and SCLK is low when chip select rises. After an invalid frame the next response is 16'h8000, and no register changes.
- R6: While chip select is high, SDO is disabled and driven 0, and SCLK and SDI toggles change no state.
- R7: The time between SCLK edges inside a frame is unbounded, so a frame sent as two bytes with a long pause between them is valid.
- R8: Writes to addresses 0, 1 and 4 to 15 change nothing. A read of an address from 4 to 15 returns that address in bits 14:11 and zero data.
- R9: Writing 1 to bit 2 of control word 1 produces a single-cycle gate-reset pulse. That bit always reads back 0, and the other bits are stored as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| sdo_oe_o | output | 1 | SDO output enable (pad tri-state control) |
| stat1_i | input | 11 | Status word 1 from protection logic |
| stat2_i | input | 11 | Status word 2 from protection logic |
| ctrl1_o | output | 11 | Control word 1 (gate configuration) |
| ctrl2_o | output | 11 | Control word 2 (amplifier and misc configuration) |
| gate_reset_o | output | 1 | Single-cycle gate fault reset pulse |

## Verification
On every cycle the assertions check four things: that SDO is released once chip select has been high for a while, that the gate-reset pulse lasts one cycle and follows a valid frame, that the control outputs hold unless a valid frame ends, and that the fault flag of the pending response matches the validity of the frame that just ended. The bench scenarios are the only place where a returned word can be matched against the command that caused it, across the full frame pipeline. The same holds for the bit ordering, for the different kinds of malformed frame, for writes to read-only addresses, and for the split two-byte frame with a long pause.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int FRAME_BITS = 16;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 11;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  localparam logic [ADDR_W-1:0] ADDR_STAT1 = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT2 = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL1 = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL2 = 4'd3;

  localparam int GATE_RST_BIT = 2;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } spi_cmd_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= {STAGES{RST_VAL[b]}};
      else         chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_prev_o <= RST_VAL;
    else         q_prev_o <= q_o;
  end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_reg_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_s_i,
  input  logic                  sclk_p_i,
  input  logic                  cs_s_i,
  input  logic                  cs_p_i,
  input  logic                  sdi_s_i,
  input  logic [FRAME_BITS-1:0] resp_word_i,
  output logic                  sdo_o,
  output logic                  sdo_oe_o,
  output logic                  done_o,
  output logic                  ok_o,
  output logic [FRAME_BITS-1:0] word_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

  logic                  in_frame, bad_start, sdo_q;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-1:0] sh_in, sh_out;
  logic                  cs_fall, cs_rise, sclk_rise, sclk_fall;

  assign cs_fall   =  cs_p_i & ~cs_s_i;
  assign cs_rise   = ~cs_p_i &  cs_s_i;
  assign sclk_rise =  sclk_s_i & ~sclk_p_i;
  assign sclk_fall = ~sclk_s_i &  sclk_p_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame  <= 1'b0;
      bad_start <= 1'b0;
      sdo_q     <= 1'b0;
      cnt       <= '0;
      sh_in     <= '0;
      sh_out    <= '0;
      done_o    <= 1'b0;
      ok_o      <= 1'b0;
      word_o    <= '0;
    end else begin
      done_o <= 1'b0;
      if (cs_fall) begin
        in_frame  <= 1'b1;
        bad_start <= sclk_s_i;
        cnt       <= '0;
        sh_out    <= resp_word_i;
        sdo_q     <= 1'b0;
      end else if (cs_rise) begin
        if (in_frame) begin
          done_o <= 1'b1;
          ok_o   <= ~bad_start & (cnt == CNT_FULL) & ~sclk_s_i;
          word_o <= sh_in;
        end
        in_frame <= 1'b0;
        sdo_q    <= 1'b0;
      end else if (in_frame) begin
        if (sclk_rise) begin
          sdo_q  <= sh_out[FRAME_BITS-1];
          sh_out <= {sh_out[FRAME_BITS-2:0], 1'b0};
        end
        if (sclk_fall) begin
          sh_in <= {sh_in[FRAME_BITS-2:0], sdi_s_i};
          if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign sdo_oe_o = in_frame;
  assign sdo_o    = in_frame & sdo_q;
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
  import spi_reg_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  done_i,
  input  logic                  ok_i,
  input  logic [FRAME_BITS-1:0] word_i,
  input  logic [DATA_W-1:0]     stat1_i,
  input  logic [DATA_W-1:0]     stat2_i,
  output logic [DATA_W-1:0]     ctrl1_o,
  output logic [DATA_W-1:0]     ctrl2_o,
  output logic                  gate_reset_o,
  output logic [FRAME_BITS-1:0] resp_word_o
);
  spi_cmd_t          cmd;
  logic              resp_fault;
  logic [ADDR_W-1:0] resp_addr;
  logic [DATA_W-1:0] resp_data;

  assign cmd = spi_cmd_t'(word_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_fault   <= 1'b0;
      resp_addr    <= ADDR_STAT1;
      ctrl1_o      <= '0;
      ctrl2_o      <= '0;
      gate_reset_o <= 1'b0;
    end else begin
      gate_reset_o <= 1'b0;
      if (done_i) begin
        if (!ok_i) begin
          resp_fault <= 1'b1;
        end else begin
          resp_fault <= 1'b0;
          if (cmd.rd) begin
            resp_addr <= cmd.addr;
          end else begin
            resp_addr <= ADDR_STAT1;
            if (cmd.addr == ADDR_CTRL1) begin
              ctrl1_o               <= cmd.data;
              ctrl1_o[GATE_RST_BIT] <= 1'b0;  // self-clearing command bit
              gate_reset_o          <= cmd.data[GATE_RST_BIT];
            end else if (cmd.addr == ADDR_CTRL2) begin
              ctrl2_o <= cmd.data;
            end
          end
        end
      end
    end
  end

  // Data is taken live when the next frame loads its response.
  always_comb begin
    case (resp_addr)
      ADDR_STAT1: resp_data = stat1_i;
      ADDR_STAT2: resp_data = stat2_i;
      ADDR_CTRL1: resp_data = ctrl1_o;
      ADDR_CTRL2: resp_data = ctrl2_o;
      default:    resp_data = '0;
    endcase
  end

  assign resp_word_o = resp_fault ? {1'b1, {(FRAME_BITS-1){1'b0}}}
                                  : {1'b0, resp_addr, resp_data};
endmodule

// File: rtl/spi_reg_if.sv
module spi_reg_if
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic [DATA_W-1:0] stat1_i,
  input  logic [DATA_W-1:0] stat2_i,
  output logic [DATA_W-1:0] ctrl1_o,
  output logic [DATA_W-1:0] ctrl2_o,
  output logic              gate_reset_o
);
  logic [2:0]            pins_s, pins_p;
  logic                  frame_done, frame_ok;
  logic [FRAME_BITS-1:0] frame_word, resp_word;

  // bit 0 sclk, bit 1 cs_n (idles high), bit 2 sdi
  spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      ({sdi_i, cs_ni, sclk_i}),
    .q_o      (pins_s),
    .q_prev_o (pins_p)
  );

  spi_frame_engine u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_s_i    (pins_s[0]),
    .sclk_p_i    (pins_p[0]),
    .cs_s_i      (pins_s[1]),
    .cs_p_i      (pins_p[1]),
    .sdi_s_i     (pins_s[2]),
    .resp_word_i (resp_word),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o),
    .done_o      (frame_done),
    .ok_o        (frame_ok),
    .word_o      (frame_word)
  );

  spi_reg_file u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .done_i       (frame_done),
    .ok_i         (frame_ok),
    .word_i       (frame_word),
    .stat1_i      (stat1_i),
    .stat2_i      (stat2_i),
    .ctrl1_o      (ctrl1_o),
    .ctrl2_o      (ctrl2_o),
    .gate_reset_o (gate_reset_o),
    .resp_word_o  (resp_word)
  );

  // pins_p[2] is only kept for symmetry of the synchronizer
  logic unused_sdi_prev;
  assign unused_sdi_prev = pins_p[2];
endmodule

// File: rtl/spi_reg_if_chk.sv
module spi_reg_if_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_ni,
  input logic        sdo_o,
  input logic        sdo_oe_o,
  input logic        gate_reset_o,
  input logic [10:0] ctrl1_o,
  input logic [10:0] ctrl2_o,
  input logic        frame_done,
  input logic        frame_ok,
  input logic        resp_msb
);
  logic [2:0] cs_hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cs_hi_cnt <= '0;
    else if (!cs_ni)           cs_hi_cnt <= '0;
    else if (cs_hi_cnt != 3'd7) cs_hi_cnt <= cs_hi_cnt + 3'd1;
  end

  p_oe_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_hi_cnt >= 3'd5) |-> !sdo_oe_o);

  p_sdo_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);

  p_gate_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_reset_o |=> !gate_reset_o);

  p_gate_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_reset_o |-> $past(frame_done && frame_ok));

  p_ctrl_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_done && frame_ok) |=> ($stable(ctrl1_o) && $stable(ctrl2_o)));

  p_bad_resp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && !frame_ok) |=> resp_msb);

  p_good_resp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && frame_ok) |=> !resp_msb);
endmodule

bind spi_reg_if spi_reg_if_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_ni        (cs_ni),
  .sdo_o        (sdo_o),
  .sdo_oe_o     (sdo_oe_o),
  .gate_reset_o (gate_reset_o),
  .ctrl1_o      (ctrl1_o),
  .ctrl2_o      (ctrl2_o),
  .frame_done   (frame_done),
  .frame_ok     (frame_ok),
  .resp_msb     (resp_word[15])
);

// File: tb/sim_spi_reg_if.sv
module sim_spi_reg_if;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, gate_rst;
  logic [10:0] stat1 = '0, stat2 = '0, ctrl1, ctrl2;

  int checks = 0, fails = 0, cycles = 0, pulses = 0;
  bit done = 0;

  // model state
  logic        m_fault = 1'b0;
  logic [3:0]  m_addr  = 4'd0;
  logic [10:0] m_c1 = '0, m_c2 = '0;
  int          m_pulses = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_reg_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .stat1_i(stat1), .stat2_i(stat2),
    .ctrl1_o(ctrl1), .ctrl2_o(ctrl2), .gate_reset_o(gate_rst)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && gate_rst) pulses <= pulses + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_resp();
    logic [10:0] d;
    if (m_fault) return 16'h8000;
    case (m_addr)
      4'd0: d = stat1;
      4'd1: d = stat2;
      4'd2: d = m_c1;
      4'd3: d = m_c2;
      default: d = '0;
    endcase
    return {1'b0, m_addr, d};
  endfunction

  function automatic void model_update(input logic [15:0] w, input bit valid);
    if (!valid) begin
      m_fault = 1'b1;
      return;
    end
    m_fault = 1'b0;
    if (w[15]) m_addr = w[14:11];
    else begin
      m_addr = 4'd0;
      if (w[14:11] == 4'd2) begin
        m_c1 = w[10:0] & ~11'd4;
        if (w[2]) m_pulses++;
      end else if (w[14:11] == 4'd3) m_c2 = w[10:0];
    end
  endfunction

  task automatic frame(input logic [15:0] w, input int nbits, input bit hi_start,
                       input bit hi_end, input int gap, input string tag);
    logic [15:0] r, e;
    bit valid;
    r = '0;
    e = exp_resp();
    valid = (nbits == 16) && !hi_start && !hi_end;
    if (hi_start) begin sclk = 1'b1; wait_clk(HALF); end
    cs_n = 1'b0; wait_clk(HALF);
    if (hi_start) begin sclk = 1'b0; wait_clk(HALF); end
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      sdi  = (i < 16) ? w[15-i] : 1'b0;
      wait_clk(HALF);
      r = {r[14:0], sdo};
      sclk = 1'b0;
      wait_clk(HALF);
      if (i == 7) wait_clk(gap);
    end
    if (hi_end) begin sclk = 1'b1; wait_clk(HALF); end
    cs_n = 1'b1; wait_clk(HALF + 2);
    sclk = 1'b0; wait_clk(HALF);
    if (nbits == 16 && !hi_start) chk(tag, r, e);
    model_update(w, valid);
    chk({tag, " ctrl1"}, ctrl1, m_c1);
    chk({tag, " ctrl2"}, ctrl2, m_c2);
  endtask

  initial begin
    wait_clk(200000 / 2 + 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    stat1 = 11'h5C3; stat2 = 11'h00A;
    wait_clk(3); rst_n = 1'b1; wait_clk(3);

    // R1 reset state
    chk("R1 ctrl1", ctrl1, 0);
    chk("R1 ctrl2", ctrl2, 0);
    chk("R1 oe", sdo_oe, 0);
    frame(16'h1000, 16, 0, 0, 0, "R1 first response");

    // R2 bit order: write a pattern then read it back
    frame({1'b0, 4'd3, 11'h5A5}, 16, 0, 0, 0, "R2 write ctrl2");
    chk("R2 ctrl2 pattern", ctrl2, 11'h5A5);
    frame({1'b1, 4'd3, 11'h000}, 16, 0, 0, 0, "R4 write response stat1");
    frame({1'b1, 4'd1, 11'h000}, 16, 0, 0, 0, "R2 read ctrl2 data");
    frame({1'b1, 4'd0, 11'h000}, 16, 0, 0, 0, "R3 read stat2");

    // R8 writes to read-only and unused addresses, read of unused
    frame({1'b0, 4'd0, 11'h7FF}, 16, 0, 0, 0, "R3 read stat1");
    frame({1'b0, 4'd9, 11'h7FF}, 16, 0, 0, 0, "R8 ro write resp");
    frame({1'b1, 4'd12, 11'h000}, 16, 0, 0, 0, "R8 unused write resp");
    frame({1'b1, 4'd2, 11'h000}, 16, 0, 0, 0, "R8 unused read zero");
    chk("R8 ctrl1 untouched", ctrl1, 0);

    // R9 gate reset bit
    frame({1'b0, 4'd2, 11'h7FF}, 16, 0, 0, 0, "R3 read ctrl1");
    chk("R9 pulse count", pulses, m_pulses);
    chk("R9 bit2 clear", ctrl1[2], 0);

    // R5 invalid frames discard writes
    frame({1'b0, 4'd3, 11'h111}, 15, 0, 0, 0, "R5 short");
    frame({1'b1, 4'd0, 11'h000}, 16, 0, 0, 0, "R5 fault after short");
    frame({1'b0, 4'd3, 11'h222}, 17, 0, 0, 0, "R5 long");
    frame({1'b0, 4'd3, 11'h333}, 16, 1, 0, 0, "R5 sclk high at start");
    frame({1'b0, 4'd3, 11'h444}, 16, 0, 1, 0, "R5 sclk high at end");
    frame({1'b1, 4'd3, 11'h000}, 16, 0, 0, 0, "R5 fault after end error");
    chk("R5 ctrl2 kept", ctrl2, 11'h5A5);

    // R6 toggles while deselected
    for (int i = 0; i < 30; i++) begin
      sclk = $urandom % 2; sdi = $urandom % 2; wait_clk(2);
      chk("R6 oe low", sdo_oe, 0);
    end
    sclk = 1'b0; wait_clk(HALF);
    frame({1'b1, 4'd3, 11'h000}, 16, 0, 0, 0, "R6 state kept");

    // R7 split two-byte frame with long pause
    frame({1'b0, 4'd2, 11'h3F8}, 16, 0, 0, 300, "R7 split write");
    chk("R7 ctrl1 split", ctrl1, 11'h3F8);

    // random mix
    for (int n = 0; n < 120; n++) begin
      int kind;
      logic [15:0] w;
      kind = $urandom % 10;
      w = {$urandom % 2 == 0 ? 1'b1 : 1'b0, 4'($urandom % 6), 11'($urandom)};
      stat1 = 11'($urandom); stat2 = 11'($urandom);
      wait_clk(4);
      case (kind)
        0: frame(w, 15, 0, 0, 0, "R5 rnd short");
        1: frame(w, 17, 0, 0, 0, "R5 rnd long");
        2: frame(w, 16, 1, 0, 0, "R5 rnd start");
        3: frame(w, 16, 0, 1, 0, "R5 rnd end");
        4: frame(w, 16, 0, 0, 20, "R7 rnd gap");
        default: frame(w, 16, 0, 0, 0, "R3 R4 rnd");
      endcase
    end
    chk("R9 final pulse count", pulses, m_pulses);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule